// File: doc/BRIEF.md
# Quarter-Wave Sine/Cosine Phase Converter

This block turns an unsigned phase index into a sine and a cosine amplitude. The index spans one full turn. Angles are counted anticlockwise from 0°, and the two top bits of the index name the quadrant. Only the first quarter of a sine wave is stored, in a table with a synchronous read. The design computes that table at elaboration. The other three quadrants are derived from the stored quarter by reading it mirrored and by negating the result.

A phase is accepted on any cycle in which its strobe is high. Two clock edges later, the sine and cosine for that phase appear together with an output strobe. Phases may be presented back to back. The cosine path uses the same folding logic on the phase advanced by a quarter turn, through a second read port on the same table. Both results are signed fixed point, twice the table width, with as many integer bits as fractional bits. The two peaks, +1.0 and −1.0, do not come from the table. They are produced as exact values.

Top module: `sincos_quarter_lut`

## Requirements
- R1: The phase is log2(4×DEPTH) bits wide, and its top two bits give the quadrant, with 0 for I through 3 for IV. In quadrant I, the sine output equals the table entry addressed by the low phase bits.
- R2: In quadrant II, the sine output equals the table entry at DEPTH minus the low phase bits.
- R3: In quadrant III the table is read directly, and in quadrant IV it is read mirrored. In both, the output is the two's-complement negation of the entry, so sine is never negative in quadrants I and II.
- R4: Table entry i equals round(2^W × sin(i × 90° / DEPTH)), clipped to 2^W − 1. Each output is a 2W-bit signed value with W fractional bits. With DEPTH=64 and W=8, phase 63 gives 0x00FF.
- R5: Phase DEPTH (90°) gives exactly +1.0 (0x0100 for W=8). Phase 3×DEPTH (270°) gives exactly −1.0 (0xFF00). This applies on both outputs.
- R6: The cosine output equals the sine of (phase + DEPTH) mod 4×DEPTH. For example, phase 0 gives cosine +1.0.
- R7: The output strobe is high exactly two clock edges after an accepted phase, for one cycle per accepted phase. Back-to-back phases give back-to-back results in order.
- R8: Reset clears the output strobe and both outputs to zero.
- R9: While no new result is delivered, the sine and cosine outputs hold their last values, even when the phase input changes.
- R10: With DEPTH=64 and W=8, phase 21 gives sine 0x007E, phase 224 gives sine 0xFF4B, and phase 43 gives sine 0x00DF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_vld_i | input | 1 | Phase strobe |
| phase_i | input | log2(4×DEPTH) | Phase index over a full turn |
| amp_vld_o | output | 1 | Result strobe |
| sin_o | output | 2×TBL_W | Signed sine, W fractional bits |
| cos_o | output | 2×TBL_W | Signed cosine, W fractional bits |

## Verification
The bench sweeps every phase and compares both outputs with a reference built from real-valued sine.

- A fold that is off by one in the mirrored quadrants would show as a shifted value just past 90° and 270°.
- A design that reaches the peaks through the table would emit 0x00FF instead of 0x0100 and 0xFF01 instead of 0xFF00.
- A sign or peak flag that is not delayed to match the table read would pair the data of one phase with the sign of the next during back-to-back streaming.
- The clip at index DEPTH−1, the hold of the outputs while idle, and a reset taken in the middle of a stream are each checked on their own.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  typedef struct packed {
    logic neg;     // negate table value
    logic pk_pos;  // force +1.0
    logic pk_neg;  // force -1.0
  } fold_flags_t;

  // round(2^w * sin(idx*pi/(2*depth))) via series, clipped to 2^w-1
  function automatic int quarter_sine_code(input int idx, input int depth, input int w);
    real x;
    real term;
    real acc;
    real scaled;
    int  code;
    x    = 1.5707963267948966 * real'(idx) / real'(depth);
    term = x;
    acc  = x;
    for (int k = 1; k < 12; k++) begin
      term = -term * x * x / real'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    scaled = acc * (2.0 ** w);
    code   = int'(scaled);
    if (code > (1 << w) - 1) code = (1 << w) - 1;
    if (code < 0) code = 0;
    return code;
  endfunction

endpackage

// File: rtl/quad_fold.sv
module quad_fold
  import sincos_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PW    = $clog2(4 * DEPTH),
  localparam int IW   = PW - 2
) (
  input  logic [PW-1:0] phase_i,
  output logic [IW-1:0] idx_o,
  output fold_flags_t   flags_o
);

  logic [1:0]    quad;
  logic [IW-1:0] low;
  logic [IW:0]   mir;

  assign quad = phase_i[PW-1:PW-2];
  assign low  = phase_i[IW-1:0];
  assign mir  = (IW+1)'(DEPTH) - {1'b0, low};

  // quadrants II and IV walk the table backwards
  assign idx_o = quad[0] ? mir[IW-1:0] : low;

  assign flags_o.neg    = quad[1];
  assign flags_o.pk_pos = (quad == 2'd1) && (low == '0);
  assign flags_o.pk_neg = (quad == 2'd3) && (low == '0);

endmodule

// File: rtl/quarter_rom.sv
module quarter_rom
  import sincos_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  parameter int NRD   = 2,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic [IW-1:0] addr_i [NRD],
  output logic [W-1:0]  data_o [NRD]
);

  logic [W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    localparam logic [W-1:0] CODE = W'(quarter_sine_code(g, DEPTH, W));
    assign tbl[g] = CODE;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_port
    logic [W-1:0] rd_q;
    always_ff @(posedge clk_i) begin
      if (en_i) rd_q <= tbl[addr_i[p]];
    end
    assign data_o[p] = rd_q;
  end

endmodule

// File: rtl/amp_stage.sv
module amp_stage
  import sincos_pkg::*;
#(
  parameter int W   = 8,
  localparam int OW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [W-1:0]  code_i,
  input  fold_flags_t   flags_i,
  output logic [OW-1:0] amp_o
);

  localparam logic [OW-1:0] POS_ONE = {{(W-1){1'b0}}, 1'b1, {W{1'b0}}};
  localparam logic [OW-1:0] NEG_ONE = {{W{1'b1}}, {W{1'b0}}};

  logic [OW-1:0] mag;
  logic [OW-1:0] nxt;

  assign mag = {{W{1'b0}}, code_i};

  always_comb begin
    if (flags_i.pk_pos)      nxt = POS_ONE;
    else if (flags_i.pk_neg) nxt = NEG_ONE;
    else if (flags_i.neg)    nxt = '0 - mag;
    else                     nxt = mag;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    amp_o <= '0;
    else if (vld_i) amp_o <= nxt;
  end

endmodule

// File: rtl/sincos_quarter_lut.sv
module sincos_quarter_lut
  import sincos_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int TBL_W  = 8,
  localparam int PW    = $clog2(4 * DEPTH),
  localparam int OW    = 2 * TBL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          phase_vld_i,
  input  logic [PW-1:0] phase_i,
  output logic          amp_vld_o,
  output logic [OW-1:0] sin_o,
  output logic [OW-1:0] cos_o
);

  localparam int IW = PW - 2;
  localparam int NCH = 2;  // 0: sine, 1: cosine

  logic [PW-1:0]    ch_phase [NCH];
  logic [IW-1:0]    ch_idx   [NCH];
  fold_flags_t      ch_flg   [NCH];
  fold_flags_t      flg_s1   [NCH];
  logic [TBL_W-1:0] rd_data  [NCH];
  logic [OW-1:0]    amp      [NCH];
  logic             vld_s1;

  assign ch_phase[0] = phase_i;
  assign ch_phase[1] = phase_i + PW'(DEPTH);  // quarter-turn advance wraps

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    quad_fold #(.DEPTH(DEPTH), .PW(PW)) i_fold (
      .phase_i (ch_phase[c]),
      .idx_o   (ch_idx[c]),
      .flags_o (ch_flg[c])
    );

    amp_stage #(.W(TBL_W)) i_amp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .vld_i   (vld_s1),
      .code_i  (rd_data[c]),
      .flags_i (flg_s1[c]),
      .amp_o   (amp[c])
    );
  end

  quarter_rom #(.DEPTH(DEPTH), .W(TBL_W), .NRD(NCH)) i_rom (
    .clk_i  (clk_i),
    .en_i   (phase_vld_i),
    .addr_i (ch_idx),
    .data_o (rd_data)
  );

  // flags ride alongside the table read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_s1 <= 1'b0;
      for (int c = 0; c < NCH; c++) flg_s1[c] <= '0;
    end else begin
      vld_s1 <= phase_vld_i;
      if (phase_vld_i) begin
        for (int c = 0; c < NCH; c++) flg_s1[c] <= ch_flg[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) amp_vld_o <= 1'b0;
    else         amp_vld_o <= vld_s1;
  end

  assign sin_o = amp[0];
  assign cos_o = amp[1];

endmodule

// File: rtl/sincos_quarter_lut_chk.sv
module sincos_quarter_lut_chk #(
  parameter int DEPTH = 64,
  parameter int TBL_W = 8,
  localparam int PW   = $clog2(4 * DEPTH),
  localparam int OW   = 2 * TBL_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          phase_vld_i,
  input logic [PW-1:0] phase_i,
  input logic          amp_vld_o,
  input logic [OW-1:0] sin_o,
  input logic [OW-1:0] cos_o
);

  localparam logic [OW-1:0] POS_ONE = {{(TBL_W-1){1'b0}}, 1'b1, {TBL_W{1'b0}}};

  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2) |-> (amp_vld_o == $past(phase_vld_i, 2)));  // R7

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !amp_vld_o |-> ($stable(sin_o) && $stable(cos_o)));  // R9

  AST_PEAK_90: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2 && $past(phase_vld_i, 2) && $past(phase_i, 2) == PW'(DEPTH))
    |-> (sin_o == POS_ONE));  // R5

  AST_UPPER_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2 && amp_vld_o && !$past(phase_i[PW-1], 2))
    |-> !sin_o[OW-1]);  // R3

  AST_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_vld_o |-> ($signed(sin_o) <= $signed(POS_ONE) && $signed(sin_o) >= -$signed(POS_ONE)));  // R4

  AST_COS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2 && $past(phase_vld_i, 2) && $past(phase_i, 2) == '0)
    |-> (cos_o == POS_ONE));  // R6

endmodule

bind sincos_quarter_lut sincos_quarter_lut_chk #(.DEPTH(DEPTH), .TBL_W(TBL_W)) i_chk (.*);

// File: tb/test_sincos_quarter_lut.sv
module test_sincos_quarter_lut;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int W     = 8;
  localparam int PW    = $clog2(4 * DEPTH);
  localparam int OW    = 2 * W;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          phase_vld_i;
  logic [PW-1:0] phase_i;
  logic          amp_vld_o;
  logic [OW-1:0] sin_o;
  logic [OW-1:0] cos_o;

  int n_checks = 0;
  int n_err    = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  sincos_quarter_lut #(.DEPTH(DEPTH), .TBL_W(W)) i_sincos_quarter_lut (
    .clk_i, .rst_ni, .phase_vld_i, .phase_i, .amp_vld_o, .sin_o, .cos_o
  );

  function automatic int ent(input int i);
    real v;
    int  c;
    v = $sin(3.14159265358979 * real'(i) / (2.0 * real'(DEPTH))) * (2.0 ** W);
    c = $rtoi(v + 0.5);
    if (c > (1 << W) - 1) c = (1 << W) - 1;
    return c;
  endfunction

  function automatic int exp_sin(input int ph);
    int p, q, l;
    p = ph % (4 * DEPTH);
    q = p / DEPTH;
    l = p % DEPTH;
    if (p == DEPTH)     return 1 << W;
    if (p == 3 * DEPTH) return -(1 << W);
    case (q)
      0:       return ent(l);
      1:       return ent(DEPTH - l);
      2:       return -ent(l);
      default: return -ent(DEPTH - l);
    endcase
  endfunction

  function automatic int sv(input logic [OW-1:0] x);
    return int'($signed(x));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d (0x%h) expected %0d (0x%h)", req, act, act[OW-1:0], expv, expv[OW-1:0]);
    end
  endtask

  // drive one phase, return at the negedge where its result is visible
  task automatic apply(input int p);
    @(negedge clk_i);
    phase_i     = PW'(p);
    phase_vld_i = 1'b1;
    @(negedge clk_i);
    phase_vld_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_reset_state();
    check(amp_vld_o == 1'b0, "R8 valid after reset", int'(amp_vld_o), 0);
    check(sin_o == '0, "R8 sin after reset", sv(sin_o), 0);
    check(cos_o == '0, "R8 cos after reset", sv(cos_o), 0);
  endtask

  task automatic t_known_points();
    apply(21);
    check(sin_o == 16'h007E, "R10 phase 21", sv(sin_o), 'h7E);
    apply(224);
    check(sin_o == 16'hFF4B, "R10 phase 224", sv(sin_o), sv(16'hFF4B));
    apply(43);
    check(sin_o == 16'h00DF, "R10 phase 43", sv(sin_o), 'hDF);
    apply(DEPTH - 1);
    check(sin_o == 16'h00FF, "R4 clip at last entry", sv(sin_o), 'hFF);
  endtask

  task automatic t_peaks();
    apply(DEPTH);
    check(sin_o == 16'h0100, "R5 sin 90", sv(sin_o), 256);
    check(cos_o == '0, "R6 cos 90", sv(cos_o), 0);
    apply(3 * DEPTH);
    check(sin_o == 16'hFF00, "R5 sin 270", sv(sin_o), -256);
    apply(0);
    check(cos_o == 16'h0100, "R5 cos 0", sv(cos_o), 256);
    apply(2 * DEPTH);
    check(cos_o == 16'hFF00, "R5 cos 180", sv(cos_o), -256);
  endtask

  task automatic t_sweep();
    for (int p = 0; p < 4 * DEPTH; p++) begin
      int q;
      string rq;
      apply(p);
      q  = p / DEPTH;
      rq = (q == 0) ? "R1 quadrant I" : (q == 1) ? "R2 quadrant II" : "R3 quadrant III/IV";
      check(sv(sin_o) == exp_sin(p), rq, sv(sin_o), exp_sin(p));  // R4 table contents
      check(sv(cos_o) == exp_sin(p + DEPTH), "R6 cosine", sv(cos_o), exp_sin(p + DEPTH));
    end
  endtask

  task automatic t_latency_stream();
    int ph [10];
    for (int i = 0; i < 10; i++) ph[i] = (i * 37 + 5) % (4 * DEPTH);
    @(negedge clk_i);
    phase_i     = PW'(ph[0]);
    phase_vld_i = 1'b1;
    @(negedge clk_i);
    check(amp_vld_o == 1'b0, "R7 no result after one edge", int'(amp_vld_o), 0);
    for (int n = 1; n < 12; n++) begin
      phase_vld_i = (n < 10);
      if (n < 10) phase_i = PW'(ph[n]);
      @(negedge clk_i);
      // result of phase n-1 visible now
      check(amp_vld_o == 1'b1, "R7 valid in stream", int'(amp_vld_o), 1);
      check(sv(sin_o) == exp_sin(ph[n-1]), "R7 stream sin order", sv(sin_o), exp_sin(ph[n-1]));
      check(sv(cos_o) == exp_sin(ph[n-1] + DEPTH), "R7 stream cos order", sv(cos_o), exp_sin(ph[n-1] + DEPTH));
      if (n == 10) break;
    end
    @(negedge clk_i);
    check(amp_vld_o == 1'b0, "R7 valid drops after stream", int'(amp_vld_o), 0);
  endtask

  task automatic t_hold();
    apply(21);
    for (int i = 0; i < 5; i++) begin
      phase_i = PW'(200 + i);
      @(negedge clk_i);
      check(sin_o == 16'h007E, "R9 sin held", sv(sin_o), 'h7E);
      check(sv(cos_o) == exp_sin(21 + DEPTH), "R9 cos held", sv(cos_o), exp_sin(21 + DEPTH));
      check(amp_vld_o == 1'b0, "R9 no strobe while idle", int'(amp_vld_o), 0);
    end
  endtask

  task automatic t_reset_midrun();
    @(negedge clk_i);
    phase_i     = PW'(100);
    phase_vld_i = 1'b1;
    @(negedge clk_i);
    phase_i = PW'(101);
    @(negedge clk_i);
    phase_vld_i = 1'b0;
    rst_ni      = 1'b0;
    #1;
    check(amp_vld_o == 1'b0, "R8 valid cleared midrun", int'(amp_vld_o), 0);
    check(sin_o == '0, "R8 sin cleared midrun", sv(sin_o), 0);
    check(cos_o == '0, "R8 cos cleared midrun", sv(cos_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    check(amp_vld_o == 1'b0, "R8 no stale result after reset", int'(amp_vld_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    rst_ni      = 1'b0;
    phase_vld_i = 1'b0;
    phase_i     = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_state();
    t_known_points();
    t_peaks();
    t_sweep();
    t_latency_stream();
    t_hold();
    t_reset_midrun();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule